// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces the two cross-port interrupt flags for a two-port shared byte memory. The two highest addresses serve as mailboxes: the byte just below the top belongs to the left port and the top byte belongs to the right port. When one port writes the other port's mailbox, the block raises an interrupt toward the owner. The owner clears it by accessing its own mailbox with select and output enable both asserted.

The mailbox bytes themselves are held in the ordinary memory array, not here. The block only observes each port's select, output enable, write strobe, address and busy input, and keeps one registered flag per port. A port whose busy input is low cannot set a flag. A set and a clear that land on the same flag in the same cycle resolve in favour of the set, so a new message is never lost.

Top module: `mailbox_irq`

## Requirements
- R1: The left interrupt (`lt_irq_n`) goes low on the clock edge after a cycle in which the right port has `rt_sel_n`=0, `rt_wr_n`=0, `rt_busy_n`=1 and `rt_addr` equal to 0x3FE, the left mailbox for 10 address bits.
- R2: A low left interrupt returns high on the clock edge after a cycle in which the left port has `lt_sel_n`=0, `lt_oe_n`=0 and `lt_addr`=0x3FE, whatever the value of `lt_wr_n`.
- R3: The right interrupt (`rt_irq_n`) goes low on the clock edge after a cycle in which the left port has `lt_sel_n`=0, `lt_wr_n`=0, `lt_busy_n`=1 and `lt_addr` equal to 0x3FF, the right mailbox.
- R4: A low right interrupt returns high on the clock edge after a cycle in which the right port has `rt_sel_n`=0, `rt_oe_n`=0 and `rt_addr`=0x3FF, whatever the value of `rt_wr_n`.
- R5: A write that would set a flag leaves that flag unchanged while the writing port's busy input is low. The busy input of the other port has no effect on that set.
- R6: No other access changes a flag: writes to any other address, a port writing its own mailbox, and an access to a mailbox with either select or output enable high all leave both interrupts as they were.
- R7: When a set and a clear reach the same flag in the same cycle, the flag goes low (set wins).
- R8: With `rst_n` low at a clock edge both interrupts become high whatever the port inputs; with no qualifying access a flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lt_sel_n | input | 1 | Left port select, active low |
| lt_oe_n | input | 1 | Left port output enable, active low |
| lt_wr_n | input | 1 | Left port write strobe, active low |
| lt_addr | input | ADDR_W | Left port address |
| lt_busy_n | input | 1 | Left port busy, low blocks left writes from setting a flag |
| rt_sel_n | input | 1 | Right port select, active low |
| rt_oe_n | input | 1 | Right port output enable, active low |
| rt_wr_n | input | 1 | Right port write strobe, active low |
| rt_addr | input | ADDR_W | Right port address |
| rt_busy_n | input | 1 | Right port busy, low blocks right writes from setting a flag |
| lt_irq_n | output | 1 | Interrupt to the left port, active low |
| rt_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
The bench builds the block with the default address width of 10, which places the mailboxes at 0x3FE and 0x3FF. With that width the neighbouring byte 0x3FD and a port's own mailbox can be written to show the decode is exact. The vectors also cover simultaneous set and clear on each flag, busy on the writing port compared with busy on the other port, and a reset applied while both flags are pending and a write is in progress.

// File: rtl/mbx_pkg.sv
// Shared definitions for the mailbox interrupt logic.
// Assumes port 0 is the left port and port 1 the right port.
package mbx_pkg;

    typedef enum logic {
        PORT_LT = 1'b0,
        PORT_RT = 1'b1
    } port_id_e;

    localparam int unsigned NUM_PORTS = 2;

    // Mailbox address owned by a port: left owns top-1, right owns top.
    function automatic int unsigned box_addr(int unsigned port, int unsigned aw);
        return (32'd1 << aw) - 32'd2 + port;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
// Decodes one port's strobes into two events: a posting write into the
// peer's mailbox (qualified by this port's busy) and a take access to
// its own mailbox (select and output enable low, write strobe ignored).
// Assumes all inputs are synchronous to clk.
module mbx_port_decode #(
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned OWN_BOX  = 1022,
    parameter int unsigned PEER_BOX = 1023
) (
    input  logic              sel_n,
    input  logic              oe_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_n,
    output logic              post_hit,
    output logic              take_hit
);
    localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_BOX);
    localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_BOX);

    // Purpose: qualify a write into the other port's mailbox.
    always_comb post_hit = !sel_n && !wr_n && busy_n && (addr == PEER_A);

    // Purpose: qualify an access to this port's own mailbox.
    always_comb take_hit = !sel_n && !oe_n && (addr == OWN_A);

endmodule

// File: rtl/mbx_flag.sv
// One pending-interrupt bit with set priority over clear.
// Assumes synchronous active-low reset; output is active low.
module mbx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    output logic irq_n
);
    logic pend_q;

    // Purpose: hold the pending bit; a set in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (set_ev) pend_q <= 1'b1;
        else if (clr_ev) pend_q <= 1'b0;
    end

    // Purpose: drive the active-low interrupt pin.
    always_comb irq_n = !pend_q;

endmodule

// File: rtl/mailbox_irq.sv
// Cross-port mailbox interrupt logic for a two-port shared memory.
// A port writing the peer's mailbox raises the peer's interrupt one clock
// later; the owner clears it by accessing its own mailbox. Message bytes
// live in the memory array outside this block.
module mailbox_irq #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lt_sel_n,
    input  logic              lt_oe_n,
    input  logic              lt_wr_n,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              lt_busy_n,
    input  logic              rt_sel_n,
    input  logic              rt_oe_n,
    input  logic              rt_wr_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_busy_n,
    output logic              lt_irq_n,
    output logic              rt_irq_n
);
    import mbx_pkg::*;

    logic              sel_n  [NUM_PORTS];
    logic              oe_n   [NUM_PORTS];
    logic              wr_n   [NUM_PORTS];
    logic [ADDR_W-1:0] addr   [NUM_PORTS];
    logic              busy_n [NUM_PORTS];
    logic              post   [NUM_PORTS];
    logic              take   [NUM_PORTS];
    logic              irq_n  [NUM_PORTS];

    // Purpose: gather the two port interfaces into indexed arrays.
    always_comb begin
        sel_n[PORT_LT]  = lt_sel_n;   sel_n[PORT_RT]  = rt_sel_n;
        oe_n[PORT_LT]   = lt_oe_n;    oe_n[PORT_RT]   = rt_oe_n;
        wr_n[PORT_LT]   = lt_wr_n;    wr_n[PORT_RT]   = rt_wr_n;
        addr[PORT_LT]   = lt_addr;    addr[PORT_RT]   = rt_addr;
        busy_n[PORT_LT] = lt_busy_n;  busy_n[PORT_RT] = rt_busy_n;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        mbx_port_decode #(
            .ADDR_W  (ADDR_W),
            .OWN_BOX (box_addr(p, ADDR_W)),
            .PEER_BOX(box_addr(NUM_PORTS - 1 - p, ADDR_W))
        ) u_dec (
            .sel_n   (sel_n[p]),
            .oe_n    (oe_n[p]),
            .wr_n    (wr_n[p]),
            .addr    (addr[p]),
            .busy_n  (busy_n[p]),
            .post_hit(post[p]),
            .take_hit(take[p])
        );

        mbx_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_ev(post[NUM_PORTS - 1 - p]),
            .clr_ev(take[p]),
            .irq_n (irq_n[p])
        );
    end

    // Purpose: return the per-port interrupts to the named pins.
    always_comb begin
        lt_irq_n = irq_n[PORT_LT];
        rt_irq_n = irq_n[PORT_RT];
    end

endmodule

// File: rtl/mailbox_irq_chk.sv
// Property checker for mailbox_irq, attached by bind. Relates port
// strobes in one cycle to the interrupt pins in the next.
module mailbox_irq_chk #(
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lt_sel_n,
    input logic              lt_oe_n,
    input logic              lt_wr_n,
    input logic [ADDR_W-1:0] lt_addr,
    input logic              lt_busy_n,
    input logic              rt_sel_n,
    input logic              rt_oe_n,
    input logic              rt_wr_n,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              rt_busy_n,
    input logic              lt_irq_n,
    input logic              rt_irq_n
);
    localparam logic [ADDR_W-1:0] LBOX = ~ADDR_W'(1);
    localparam logic [ADDR_W-1:0] RBOX = ~ADDR_W'(0);

    logic lt_set_c, rt_set_c, lt_clr_c, rt_clr_c;
    always_comb begin
        lt_set_c = !rt_sel_n && !rt_wr_n && rt_busy_n && rt_addr == LBOX;
        rt_set_c = !lt_sel_n && !lt_wr_n && lt_busy_n && lt_addr == RBOX;
        lt_clr_c = !lt_sel_n && !lt_oe_n && lt_addr == LBOX;
        rt_clr_c = !rt_sel_n && !rt_oe_n && rt_addr == RBOX;
    end

    a_r1_left_set: assert property (@(posedge clk) disable iff (!rst_n)
        lt_set_c |=> !lt_irq_n);
    a_r3_right_set: assert property (@(posedge clk) disable iff (!rst_n)
        rt_set_c |=> !rt_irq_n);
    a_r2_left_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_clr_c && !lt_set_c) |=> lt_irq_n);
    a_r4_right_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_clr_c && !rt_set_c) |=> rt_irq_n);
    a_r5_busy_blocks_left: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_irq_n && !rt_busy_n) |=> lt_irq_n);
    a_r5_busy_blocks_right: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_irq_n && !lt_busy_n) |=> rt_irq_n);
    a_r8_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!lt_set_c && !lt_clr_c && rst_n) |=> $stable(lt_irq_n));
    a_r8_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (lt_irq_n && rt_irq_n));

endmodule

bind mailbox_irq mailbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .lt_sel_n(lt_sel_n), .lt_oe_n(lt_oe_n), .lt_wr_n(lt_wr_n),
    .lt_addr(lt_addr), .lt_busy_n(lt_busy_n),
    .rt_sel_n(rt_sel_n), .rt_oe_n(rt_oe_n), .rt_wr_n(rt_wr_n),
    .rt_addr(rt_addr), .rt_busy_n(rt_busy_n),
    .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
);

// File: tb/sim_mailbox_irq.sv
module sim_mailbox_irq;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lt_sel_n, lt_oe_n, lt_wr_n, lt_busy_n;
    logic rt_sel_n, rt_oe_n, rt_wr_n, rt_busy_n;
    logic [AW-1:0] lt_addr, rt_addr;
    logic lt_irq_n, rt_irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mailbox_irq #(.ADDR_W(AW)) u0 (.*);

    // port field: {sel_n, oe_n, wr_n, addr, busy_n}
    function automatic logic [13:0] pw(logic [9:0] a, logic b);
        return {1'b0, 1'b1, 1'b0, a, b};
    endfunction
    function automatic logic [13:0] pr(logic [9:0] a);
        return {1'b0, 1'b0, 1'b1, a, 1'b1};
    endfunction
    localparam logic [13:0] IDL = {1'b1, 1'b1, 1'b1, 10'h000, 1'b1};

    localparam int NV = 20;
    // vector: {left port, right port, expected lt_irq_n, expected rt_irq_n}
    localparam logic [29:0] VEC [NV] = '{
        {IDL, IDL, 2'b11},                                 // 0  R8 idle
        {IDL, pw(10'h3FE, 1'b1), 2'b01},                   // 1  R1 set left
        {IDL, IDL, 2'b01},                                 // 2  R8 hold
        {pr(10'h3FE), IDL, 2'b11},                         // 3  R2 clear left
        {pw(10'h3FF, 1'b1), IDL, 2'b10},                   // 4  R3 set right
        {IDL, {1'b0, 1'b0, 1'b0, 10'h3FF, 1'b1}, 2'b11},   // 5  R4 clear, wr low
        {IDL, pw(10'h3FE, 1'b0), 2'b11},                   // 6  R5 busy right
        {pw(10'h3FF, 1'b0), IDL, 2'b11},                   // 7  R5 busy left
        {IDL, pw(10'h3FD, 1'b1), 2'b11},                   // 8  R6 neighbour
        {pw(10'h3FE, 1'b1), pw(10'h3FF, 1'b1), 2'b11},     // 9  R6 own boxes
        {IDL, pw(10'h3FE, 1'b1), 2'b01},                   // 10 R1
        {{1'b0, 1'b1, 1'b1, 10'h3FE, 1'b1}, IDL, 2'b01},   // 11 R6 oe high
        {{1'b1, 1'b0, 1'b1, 10'h3FE, 1'b1}, IDL, 2'b01},   // 12 R6 sel high
        {pr(10'h3FE), pw(10'h3FE, 1'b1), 2'b01},           // 13 R7 left
        {pr(10'h3FE), IDL, 2'b11},                         // 14 R2
        {pw(10'h3FF, 1'b1), pr(10'h3FF), 2'b10},           // 15 R7 right
        {pw(10'h3FF, 1'b1), pw(10'h3FE, 1'b1), 2'b00},     // 16 R1 R3 both
        {pr(10'h3FE), pr(10'h3FF), 2'b11},                 // 17 R2 R4 both
        {pw(10'h3FF, 1'b1), {1'b1, 1'b1, 1'b1, 10'h000, 1'b0}, 2'b10}, // 18 R5 other busy
        {IDL, pr(10'h3FF), 2'b11}                          // 19 R4
    };

    task automatic drive(logic [13:0] l, logic [13:0] r);
        {lt_sel_n, lt_oe_n, lt_wr_n, lt_addr, lt_busy_n} = l;
        {rt_sel_n, rt_oe_n, rt_wr_n, rt_addr, rt_busy_n} = r;
    endtask

    task automatic check(string req, logic [1:0] exp);
        checks++;
        if ({lt_irq_n, rt_irq_n} !== exp) begin
            errors++;
            $display("FAIL %s: irq_n {lt,rt} got %b expected %b", req, {lt_irq_n, rt_irq_n}, exp);
        end
    endtask

    initial begin
        drive(IDL, IDL);
        repeat (3) @(negedge clk);
        check("R8 reset state", 2'b11);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][29:16], VEC[i][15:2]);
            @(negedge clk);
            check($sformatf("vector %0d", i), VEC[i][1:0]);
        end
        // R8: reset with both flags pending and a set write in progress
        drive(pw(10'h3FF, 1'b1), pw(10'h3FE, 1'b1));
        @(negedge clk);
        check("R1 R3 pre-reset", 2'b00);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset over pending", 2'b11);
        drive(IDL, IDL);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle after reset", 2'b11);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule